// File: doc/BRIEF.md
# Calendar Alarm Match Interrupt

This block watches the running minute, hour and day values that a calendar supplies, and compares them with three programmed alarm fields. When every field that software has switched on equals the current time, it sets a sticky alarm flag. If the interrupt is enabled it also drives an active-low interrupt line, which models an open-drain pin. The flag stays set until software clears it by writing 0. The comparison is made only when the calendar pulses its minute-update strobe, so one matching minute gives one event.

The third alarm field has two meanings, chosen by a mode bit. In weekday mode it holds a seven-bit mask with one bit per weekday, and any set bit that meets the current one-hot weekday counts as a match. In day-of-month mode it holds a BCD day number. When the calendar is halted by its global stop input, no events are raised. Software reaches the alarm through a small register port with four byte-wide locations.

Top module: `alarm_match_top`

## Requirements
- R1: Locations 0, 1 and 2 hold the minute, hour and day alarm bytes and read back as written. Location 3 reads back as bit0 = day mode (1 = day-of-month), bit1 = interrupt enable and bit2 = alarm flag, with the other bits reading 0. Bit 7 of each alarm byte is that field's compare enable (1 = compared).
- R2: The minute field (bits 6:0) and the hour field (bits 5:0) match only when they equal the BCD time input bit for bit.
- R3: In weekday mode, bits 6:0 of the day byte form a mask. The field matches when the mask and the one-hot weekday input share at least one set bit, so several weekdays can match.
- R4: In day-of-month mode, bits 5:0 of the day byte match only when they equal the BCD day input.
- R5: A field whose enable bit is 0 is left out of the comparison.
- R6: When none of the three enable bits is set, the flag never sets.
- R7: The flag sets on the clock edge that ends a strobe cycle in which all enabled fields match. It stays set until location 3 is written with bit2 = 0, and writing bit2 = 1 leaves it unchanged. If a clear write and a new event fall in the same cycle, the flag ends up set.
- R8: The interrupt output is low exactly while the flag and the interrupt enable are both 1. The enable has no effect on the flag.
- R9: While the stop input is 1, a matching strobe does not set the flag.
- R10: A match without the minute-update strobe does not set the flag.
- R11: After reset, all alarm bytes, the mode bit, the interrupt enable and the flag are 0, and the interrupt output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register location for writes and reads |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr (combinational) |
| minuteTick | input | 1 | One-cycle minute-update strobe from the calendar |
| stopTime | input | 1 | Global stop of timekeeping; suppresses events |
| curMin | input | 7 | Current minute, BCD |
| curHour | input | 6 | Current hour, BCD |
| curWeekday | input | 7 | Current weekday, one-hot |
| curDay | input | 6 | Current day of month, BCD |
| alarmFlag | output | 1 | Sticky alarm flag |
| irqN | output | 1 | Active-low interrupt (open-drain model, 1 = released) |

## Verification
The assertions check four things on every cycle. The interrupt output is never low without the flag. The flag only rises after a strobe cycle that was not stopped. An event is never raised while the stop input is 1. The flag holds or clears exactly as the control strobes direct. The bench scenarios show the rest, which depends on the values: bit-exact BCD equality, the weekday mask matching several days, day-of-month mode, leaving out disabled fields, the all-disabled case that never fires, and the set-over-clear priority.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] LOC_MIN  = 2'd0;
  localparam logic [ADDR_W-1:0] LOC_HOUR = 2'd1;
  localparam logic [ADDR_W-1:0] LOC_DAY  = 2'd2;
  localparam logic [ADDR_W-1:0] LOC_CTRL = 2'd3;

  // control-register bit positions
  localparam int CTRL_MODE = 0;
  localparam int CTRL_IRQE = 1;
  localparam int CTRL_FLAG = 2;

  typedef struct packed {
    logic loadMin;
    logic loadHour;
    logic loadDay;
    logic loadCtrl;
    logic clearFlag;
    logic setFlag;
  } almStrobe_t;
endpackage

// File: rtl/alarm_match_ctrl.sv
module alarm_match_ctrl
  import alarm_match_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              minuteTick,
  input  logic              stopTime,
  input  logic              matchHit,
  output almStrobe_t        str
);
  always_comb begin
    str = '0;
    str.loadMin   = regWr && (regAddr == LOC_MIN);
    str.loadHour  = regWr && (regAddr == LOC_HOUR);
    str.loadDay   = regWr && (regAddr == LOC_DAY);
    str.loadCtrl  = regWr && (regAddr == LOC_CTRL);
    // writing 1 to the flag bit is ignored; only 0 clears
    str.clearFlag = str.loadCtrl && !regWdata[CTRL_FLAG];
    // the comparison is sampled only on the minute strobe, never while halted
    str.setFlag   = minuteTick && !stopTime && matchHit;
  end

  // R9: halted timekeeping produces no event
  p_no_event_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stopTime |-> !str.setFlag);

  // R10: events only come with the minute strobe
  p_event_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    str.setFlag |-> minuteTick);
endmodule

// File: rtl/alarm_match_dp.sv
module alarm_match_dp
  import alarm_match_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int DAY_W  = 6,
  parameter int WEEK_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  almStrobe_t        str,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [MIN_W-1:0]  curMin,
  input  logic [HOUR_W-1:0] curHour,
  input  logic [WEEK_W-1:0] curWeekday,
  input  logic [DAY_W-1:0]  curDay,
  output logic              matchHit,
  output logic              flagQ,
  output logic              irqEnQ,
  output logic [DATA_W-1:0] regRdata
);
  localparam int EN_BIT = DATA_W - 1;

  logic [DATA_W-1:0] almMinQ, almHourQ, almDayQ;
  logic              dayModeQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      almMinQ  <= '0;
      almHourQ <= '0;
      almDayQ  <= '0;
      dayModeQ <= 1'b0;
      irqEnQ   <= 1'b0;
    end else begin
      if (str.loadMin)  almMinQ  <= regWdata;
      if (str.loadHour) almHourQ <= regWdata;
      if (str.loadDay)  almDayQ  <= regWdata;
      if (str.loadCtrl) begin
        dayModeQ <= regWdata[CTRL_MODE];
        irqEnQ   <= regWdata[CTRL_IRQE];
      end
    end
  end

  // a new event has priority over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             flagQ <= 1'b0;
    else if (str.setFlag)   flagQ <= 1'b1;
    else if (str.clearFlag) flagQ <= 1'b0;
  end

  // per-field comparison; a disabled field always passes
  logic minOk, hourOk, dayOk, weekHit, domHit, anyEn;
  always_comb begin
    minOk   = !almMinQ[EN_BIT]  || (almMinQ[MIN_W-1:0]  == curMin);
    hourOk  = !almHourQ[EN_BIT] || (almHourQ[HOUR_W-1:0] == curHour);
    weekHit = |(almDayQ[WEEK_W-1:0] & curWeekday);
    domHit  = (almDayQ[DAY_W-1:0] == curDay);
    dayOk   = !almDayQ[EN_BIT] || (dayModeQ ? domHit : weekHit);
    anyEn   = almMinQ[EN_BIT] | almHourQ[EN_BIT] | almDayQ[EN_BIT];
    matchHit = anyEn && minOk && hourOk && dayOk;
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      LOC_MIN:  regRdata = almMinQ;
      LOC_HOUR: regRdata = almHourQ;
      LOC_DAY:  regRdata = almDayQ;
      default: begin
        regRdata[CTRL_MODE] = dayModeQ;
        regRdata[CTRL_IRQE] = irqEnQ;
        regRdata[CTRL_FLAG] = flagQ;
      end
    endcase
  end

  // R7: the flag is sticky until a clear strobe arrives
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flagQ && !str.clearFlag |=> flagQ);

  // R7: a clear without a competing event drops the flag
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    str.clearFlag && !str.setFlag |=> !flagQ);
endmodule

// File: rtl/alarm_match_top.sv
module alarm_match_top
  import alarm_match_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int DAY_W  = 6,
  parameter int WEEK_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              minuteTick,
  input  logic              stopTime,
  input  logic [6:0]        curMin,
  input  logic [5:0]        curHour,
  input  logic [6:0]        curWeekday,
  input  logic [5:0]        curDay,
  output logic              alarmFlag,
  output logic              irqN
);
  almStrobe_t str;
  logic matchHit, irqEnQ;

  alarm_match_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .minuteTick(minuteTick), .stopTime(stopTime),
    .matchHit(matchHit), .str(str)
  );

  alarm_match_dp #(.DATA_W(DATA_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W),
                   .DAY_W(DAY_W), .WEEK_W(WEEK_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .str(str), .regWdata(regWdata),
    .regAddr(regAddr), .curMin(curMin), .curHour(curHour),
    .curWeekday(curWeekday), .curDay(curDay), .matchHit(matchHit),
    .flagQ(alarmFlag), .irqEnQ(irqEnQ), .regRdata(regRdata)
  );

  // open-drain model: 0 pulls low, 1 means released
  assign irqN = !(alarmFlag && irqEnQ);

  // R8: the line is never pulled low without a pending flag
  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irqN |-> alarmFlag);

  // R10: a rising flag follows an unstopped strobe cycle
  p_rise_after_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarmFlag) |-> $past(minuteTick && !stopTime));
endmodule

// File: tb/alarm_match_top_tb_top.sv
module alarm_match_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       regWr = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       minuteTick = 1'b0;
  logic       stopTime = 1'b0;
  logic [6:0] curMin = '0;
  logic [5:0] curHour = '0;
  logic [6:0] curWeekday = 7'h01;
  logic [5:0] curDay = 6'h01;
  logic       alarmFlag, irqN;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  alarm_match_top dut_i (
    .clk(clk), .rst_n(rst_n), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .minuteTick(minuteTick),
    .stopTime(stopTime), .curMin(curMin), .curHour(curHour),
    .curWeekday(curWeekday), .curDay(curDay), .alarmFlag(alarmFlag),
    .irqN(irqN)
  );

  // vector layout: almMin[51:44] almHour[43:36] almDay[35:28] mode[27]
  // curMin[26:20] curHour[19:14] curWeekday[13:7] curDay[6:1] expectFlag[0]
  localparam int NVEC = 11;
  localparam logic [51:0] VEC [NVEC] = '{
    {8'hB0, 8'h92, 8'h00, 1'b0, 7'h30, 6'h12, 7'h01, 6'h05, 1'b1}, // R2 match
    {8'hB0, 8'h92, 8'h00, 1'b0, 7'h31, 6'h12, 7'h01, 6'h05, 1'b0}, // R2 minute off
    {8'hB0, 8'h92, 8'h00, 1'b0, 7'h30, 6'h13, 7'h01, 6'h05, 1'b0}, // R2 hour off
    {8'h00, 8'h00, 8'hAA, 1'b0, 7'h00, 6'h00, 7'h08, 6'h01, 1'b1}, // R3 mask hit
    {8'h00, 8'h00, 8'hAA, 1'b0, 7'h00, 6'h00, 7'h20, 6'h01, 1'b1}, // R3 second day
    {8'h00, 8'h00, 8'hAA, 1'b0, 7'h00, 6'h00, 7'h04, 6'h01, 1'b0}, // R3 mask miss
    {8'h00, 8'h00, 8'h95, 1'b1, 7'h00, 6'h00, 7'h01, 6'h15, 1'b1}, // R4 day hit
    {8'h00, 8'h00, 8'h95, 1'b1, 7'h00, 6'h00, 7'h10, 6'h14, 1'b0}, // R4 day miss
    {8'h85, 8'h00, 8'h00, 1'b0, 7'h05, 6'h23, 7'h40, 6'h09, 1'b1}, // R5 minute only
    {8'h05, 8'h23, 8'h01, 1'b0, 7'h05, 6'h23, 7'h01, 6'h09, 1'b0}, // R6 none enabled
    {8'hD9, 8'h00, 8'h00, 1'b0, 7'h59, 6'h00, 7'h02, 6'h31, 1'b1}  // R2 top BCD
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic tick();
    @(negedge clk);
    minuteTick = 1'b1;
    @(negedge clk);
    minuteTick = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R11: reset state
    for (int a = 0; a < 4; a++) begin
      rdReg(a[1:0], rd);
      check("R11 reset reg", rd, 8'h00);
    end
    check("R11 reset flag", {7'b0, alarmFlag}, 8'h00);
    check("R11 reset irqN", {7'b0, irqN}, 8'h01);
    rst_n = 1'b1;

    // R1: read-back
    wrReg(2'd0, 8'hA5); rdReg(2'd0, rd); check("R1 min reg", rd, 8'hA5);
    wrReg(2'd1, 8'h5A); rdReg(2'd1, rd); check("R1 hour reg", rd, 8'h5A);
    wrReg(2'd2, 8'hC3); rdReg(2'd2, rd); check("R1 day reg", rd, 8'hC3);
    wrReg(2'd3, 8'hFB); rdReg(2'd3, rd); check("R1 ctrl reg", rd, 8'h03);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [51:0] v;
      v = VEC[i];
      wrReg(2'd3, {6'b0, 1'b1, v[27]});
      wrReg(2'd0, v[51:44]);
      wrReg(2'd1, v[43:36]);
      wrReg(2'd2, v[35:28]);
      curMin = v[26:20]; curHour = v[19:14];
      curWeekday = v[13:7]; curDay = v[6:1];
      tick();
      check($sformatf("R2-R6 vec%0d flag", i), {7'b0, alarmFlag}, {7'b0, v[0]});
      check($sformatf("R8 vec%0d irqN", i), {7'b0, irqN}, {7'b0, ~v[0]});
    end

    // common matching setup: minute 0x30 only, irq disabled
    wrReg(2'd3, 8'h00);
    wrReg(2'd0, 8'hB0); wrReg(2'd1, 8'h00); wrReg(2'd2, 8'h00);
    curMin = 7'h30;

    // R10: match held without strobe
    repeat (5) @(negedge clk);
    check("R10 no tick", {7'b0, alarmFlag}, 8'h00);

    // R9: stopped
    stopTime = 1'b1; tick(); stopTime = 1'b0;
    check("R9 stopped", {7'b0, alarmFlag}, 8'h00);

    // R8: enable does not touch flag; irq follows enable
    tick();
    check("R8 flag with irq off", {7'b0, alarmFlag}, 8'h01);
    check("R8 irqN released", {7'b0, irqN}, 8'h01);
    wrReg(2'd3, 8'h06);
    check("R8 irqN low", {7'b0, irqN}, 8'h00);
    // R7: writing 1 to flag bit ignored
    rdReg(2'd3, rd); check("R7 write1 ignored", rd, 8'h06);
    wrReg(2'd3, 8'h02);
    check("R7 cleared", {7'b0, alarmFlag}, 8'h00);
    check("R8 irqN released after clear", {7'b0, irqN}, 8'h01);

    // R7: event wins over simultaneous clear
    tick();
    @(negedge clk);
    regWr = 1'b1; regAddr = 2'd3; regWdata = 8'h02; minuteTick = 1'b1;
    @(negedge clk);
    regWr = 1'b0; minuteTick = 1'b0;
    check("R7 set beats clear", {7'b0, alarmFlag}, 8'h01);

    // R7: flag holds across non-matching strobes
    wrReg(2'd3, 8'h02);
    tick();
    curMin = 7'h31;
    tick();
    check("R7 hold", {7'b0, alarmFlag}, 8'h01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule